// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Controller

This block is the data mover for one disk interface channel. Software programs it through a small 8-bit register port. It places a table of transfer descriptors in memory, writes the table's base address, picks the transfer direction and then sets the run bit. The engine then works through the descriptors on its own. Each descriptor is a pair of 32-bit words: a buffer address and a byte count with an end-of-table flag.

For each buffer, the engine moves whole 32-bit words between the device data stream and memory. It reads memory and presents the words to the device, or it takes words from the device and writes them to memory. After the final word of the flagged descriptor it stops. Software judges the result from the status byte. The low three bits read 100b after a good transfer: interrupt seen, no error, engine idle. Every other value means the transfer failed or is unfinished. Issuing commands to the drive, the timing of the disk bus and routing the host interrupt are handled elsewhere.

Top module: `bm_dma_chan`

## Requirements
- R1: Register map on the 3-bit byte address. Offset 0 is command: bit 0 is run and bit 3 is direction, where 1 means device to memory. Offset 2 is status. Offsets 4 to 7 hold the table pointer, low byte first. Offsets 1 and 3 read as zero, command bits other than 0 and 3 read as zero, and every register resets to zero.
- R2: Writing command bit 0 as 1, while it was 0 and the engine is idle, starts the engine. Status bit 0 reads 1 from the next cycle. Direction and table pointer are taken only at that start. Rewriting 1 over 1 starts nothing, and pointer writes made during a transfer do not affect it.
- R3: A descriptor is two words: the buffer address at table+0 and the count word at table+4. Address bits 1:0 are ignored. Count bits 15:2 give the number of 32-bit words, and 0 means 16384 words (64 KiB). Count bit 31 marks the last descriptor. The next descriptor follows at table+8.
- R4: With direction 1, words taken from the device stream are written to consecutive memory word addresses starting at the buffer address, in stream order.
- R5: With direction 0, words are read from consecutive memory addresses and presented to the device stream in address order.
- R6: After the final word of the last descriptor, status bit 0 clears. Error and interrupt are left unchanged.
- R7: While the device stream supplies or accepts no data, status bit 0 stays 1, for as long as the stall lasts.
- R8: Clearing command bit 0 while the engine waits on the device stream returns it to idle within two cycles. No further memory access follows.
- R9: A memory response flagged as an error sets status bit 1, clears status bit 0 and ends the transfer. No further memory access follows.
- R10: A high device interrupt input sets status bit 2. Status bit 2 may be set while status bit 0 is still 1.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. A set event in the same cycle as the clearing write wins.
- R12: Status bits 5 and 6 are plain read/write bits that the engine never changes. Writes to status bits 0, 3, 4 and 7 have no effect.
- R13: A completed transfer followed by a device interrupt reads 100b in status bits 2:0.
- R14: A memory request keeps its address, direction and write data stable until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access completes this cycle |
| mem_err_i | input | 1 | Completing access failed |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| dev_rd_valid_i | input | 1 | Device offers a word |
| dev_rd_data_i | input | 32 | Word from device |
| dev_rd_ready_o | output | 1 | Engine takes the offered word |
| dev_wr_valid_o | output | 1 | Engine offers a word to device |
| dev_wr_data_o | output | 32 | Word to device |
| dev_wr_ready_i | input | 1 | Device takes the offered word |
| dev_irq_i | input | 1 | Device interrupt level |

## Verification
The interrupt and error flags each have two writers: an event from the device or the memory, and the host's clearing write. These can land in the same cycle. The bench holds the device interrupt high across a clearing write to status and expects the flag to read 1 afterwards. It then expects a write of 0 to that bit to leave it set, and a later clearing write with the interrupt low to clear it. A related overlap is checked as well: the interrupt arrives while the engine is stalled on the device, and the bench requires status to read 101b before the stop is issued.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam logic [2:0] OFS_CMD = 3'd0;
  localparam logic [2:0] OFS_STS = 3'd2;
  localparam int OFS_PTR = 4;
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int STS_ACT = 0;
  localparam int STS_ERR = 1;
  localparam int STS_IRQ = 2;
  localparam int STS_CAP = 5;
  localparam int DESC_LAST = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_A, ST_FETCH_C, ST_DEV, ST_MEM
  } dma_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              busy_i,
  input  logic              err_set_i,
  input  logic              irq_set_i,
  output logic              start_o,
  output logic              run_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam int NB = ADDR_W / 8;

  logic run_q, dir_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic [NB-1:0][7:0] ptr_q;

  logic wr_cmd, wr_sts;
  assign wr_cmd  = wr_i && (addr_i == OFS_CMD);
  assign wr_sts  = wr_i && (addr_i == OFS_STS);
  assign start_o = wr_cmd && wdata_i[CMD_RUN] && !run_q && !busy_i;
  assign run_o   = run_q;
  assign dir_o   = dir_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      if (wr_cmd) begin
        run_q <= wdata_i[CMD_RUN];
        dir_q <= wdata_i[CMD_DIR];
      end
      if (wr_sts) cap_q <= wdata_i[STS_CAP+1:STS_CAP];
      // set beats write-one-to-clear
      if (err_set_i)                    err_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_ERR]) err_q <= 1'b0;
      if (irq_set_i)                    irq_q <= 1'b1;
      else if (wr_sts && wdata_i[STS_IRQ]) irq_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[g] <= '0;
      else if (wr_i && addr_i == 3'(OFS_PTR + g)) ptr_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CMD: begin
        rdata_o[CMD_RUN] = run_q;
        rdata_o[CMD_DIR] = dir_q;
      end
      OFS_STS: begin
        rdata_o[STS_ACT] = busy_i;
        rdata_o[STS_ERR] = err_q;
        rdata_o[STS_IRQ] = irq_q;
        rdata_o[STS_CAP+1:STS_CAP] = cap_q;
      end
      default: if (addr_i[2]) rdata_o = ptr_q[addr_i[1:0]];
    endcase
  end

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_q);
  // R11
  err_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && wdata_i[STS_ERR] && !err_set_i) |=> !err_q);
  // R12
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sts |=> $stable(cap_q));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              dir_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              busy_o,
  output logic              err_set_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_rd_valid_i,
  input  logic [WORD_W-1:0] dev_rd_data_i,
  output logic              dev_rd_ready_o,
  output logic              dev_wr_valid_o,
  output logic [WORD_W-1:0] dev_wr_data_o,
  input  logic              dev_wr_ready_i
);
  localparam int FLD_W = LEN_W - 2;
  localparam int WC_W  = LEN_W - 1;
  localparam logic [WC_W-1:0] WC_MAX = {1'b1, {FLD_W{1'b0}}};
  localparam logic [WC_W-1:0] WC_ONE = WC_W'(1);

  dma_st_e st_q, st_after_word;
  logic              dir_q, last_q;
  logic [ADDR_W-1:0] tab_q, addr_q;
  logic [WC_W-1:0]   left_q;
  logic [WORD_W-1:0] buf_q;
  logic [FLD_W-1:0]  fld;
  logic              acc_done, word_done;

  assign busy_o         = (st_q != ST_IDLE);
  assign mem_req_o      = (st_q == ST_FETCH_A) || (st_q == ST_FETCH_C) || (st_q == ST_MEM);
  assign mem_we_o       = (st_q == ST_MEM) && dir_q;
  assign mem_wdata_o    = buf_q;
  assign dev_rd_ready_o = (st_q == ST_DEV) && dir_q && run_i;
  assign dev_wr_valid_o = (st_q == ST_DEV) && !dir_q && run_i;
  assign dev_wr_data_o  = buf_q;
  assign fld            = mem_rdata_i[LEN_W-1:2];

  always_comb begin
    case (st_q)
      ST_FETCH_A: mem_addr_o = tab_q;
      ST_FETCH_C: mem_addr_o = tab_q + ADDR_W'(4);
      default:    mem_addr_o = addr_q;
    endcase
    acc_done  = mem_req_o && mem_ack_i;
    err_set_o = acc_done && mem_err_i;
    // a word is finished when its second leg completes
    word_done = (dev_wr_valid_o && dev_wr_ready_i) ||
                ((st_q == ST_MEM) && dir_q && acc_done && !mem_err_i);
    if (left_q == WC_ONE) st_after_word = last_q ? ST_IDLE : ST_FETCH_A;
    else                  st_after_word = dir_q ? ST_DEV : ST_MEM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      last_q <= 1'b0;
      tab_q  <= '0;
      addr_q <= '0;
      left_q <= '0;
      buf_q  <= '0;
    end else if (word_done) begin
      addr_q <= addr_q + ADDR_W'(4);
      left_q <= left_q - WC_ONE;
      st_q   <= st_after_word;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          tab_q <= {ptr_i[ADDR_W-1:2], 2'b00};
          dir_q <= dir_i;
          st_q  <= ST_FETCH_A;
        end
        ST_FETCH_A: if (acc_done) begin
          if (mem_err_i) st_q <= ST_IDLE;
          else begin
            addr_q <= {mem_rdata_i[ADDR_W-1:2], 2'b00};
            st_q   <= ST_FETCH_C;
          end
        end
        ST_FETCH_C: if (acc_done) begin
          if (mem_err_i) st_q <= ST_IDLE;
          else begin
            left_q <= (fld == '0) ? WC_MAX : {1'b0, fld};
            last_q <= mem_rdata_i[DESC_LAST];
            tab_q  <= tab_q + ADDR_W'(8);
            st_q   <= dir_q ? ST_DEV : ST_MEM;
          end
        end
        ST_DEV: begin
          if (!run_i) st_q <= ST_IDLE;
          else if (dir_q && dev_rd_valid_i) begin
            buf_q <= dev_rd_data_i;
            st_q  <= ST_MEM;
          end
        end
        ST_MEM: if (acc_done) begin
          if (mem_err_i) st_q <= ST_IDLE;
          else if (!dir_q) begin
            buf_q <= mem_rdata_i;
            st_q  <= ST_DEV;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R14
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R9
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_o |=> !busy_o);
  // R2
  start_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R8
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DEV) && !run_i) |=> !busy_o);
  // R4
  one_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rd_ready_o && dev_wr_valid_o));
endmodule

// File: rtl/bm_dma_chan.sv
module bm_dma_chan
  import dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        dev_rd_valid_i,
  input  logic [31:0] dev_rd_data_i,
  output logic        dev_rd_ready_o,
  output logic        dev_wr_valid_o,
  output logic [31:0] dev_wr_data_o,
  input  logic        dev_wr_ready_i,
  input  logic        dev_irq_i
);
  logic              busy, err_set, start, run, dir;
  logic [ADDR_W-1:0] ptr;

  dma_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .err_set_i (err_set),
    .irq_set_i (dev_irq_i),
    .start_o   (start),
    .run_o     (run),
    .dir_o     (dir),
    .ptr_o     (ptr)
  );

  dma_engine #(.LEN_W(LEN_W)) u_eng (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .run_i          (run),
    .dir_i          (dir),
    .ptr_i          (ptr),
    .busy_o         (busy),
    .err_set_o      (err_set),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_ack_i      (mem_ack_i),
    .mem_err_i      (mem_err_i),
    .mem_rdata_i    (mem_rdata_i),
    .dev_rd_valid_i (dev_rd_valid_i),
    .dev_rd_data_i  (dev_rd_data_i),
    .dev_rd_ready_o (dev_rd_ready_o),
    .dev_wr_valid_o (dev_wr_valid_o),
    .dev_wr_data_o  (dev_wr_data_o),
    .dev_wr_ready_i (dev_wr_ready_i)
  );
endmodule

// File: tb/sim_bm_dma_chan.sv
`timescale 1ns/1ps
module sim_bm_dma_chan;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        dev_rd_valid_i = 1'b0;
  logic [31:0] dev_rd_data_i = '0;
  logic        dev_rd_ready_o, dev_wr_valid_o;
  logic [31:0] dev_wr_data_o;
  logic        dev_wr_ready_i = 1'b0;
  logic        dev_irq_i = 1'b0;

  always #4 clk_i = ~clk_i;

  bm_dma_chan u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [1024];
  logic [31:0] dlog [1024];
  bit slow = 0, tog = 0, err_en = 0, dev_en = 1, wr_rdy = 1, rd_pend = 0;
  logic [31:0] err_addr = '0;
  int rd_seq = 0, wr_n = 0, mem_wr_n = 0;

  // memory and device models, all driven at the falling edge
  always @(negedge clk_i) begin
    if (rd_pend) begin rd_seq++; rd_pend = 0; end
    dev_rd_data_i  = 32'hD000_0000 + 32'(rd_seq);
    dev_rd_valid_i = dev_en;
    if (dev_rd_valid_i && dev_rd_ready_o) rd_pend = 1;
    dev_wr_ready_i = wr_rdy;
    if (dev_wr_valid_o && wr_rdy) begin
      if (wr_n < 1024) dlog[wr_n] = dev_wr_data_o;
      wr_n++;
    end
    mem_ack_i   = mem_req_o && (!slow || tog);
    tog         = !tog;
    mem_err_i   = mem_ack_i && err_en && (mem_addr_o == err_addr);
    mem_rdata_i = mem[mem_addr_o[11:2]];
    if (mem_ack_i && mem_we_o && !mem_err_i) begin
      mem[mem_addr_o[11:2]] = mem_wdata_o;
      mem_wr_n++;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    tick();
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    tick();
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_ptr(logic [31:0] p);
    for (int i = 0; i < 4; i++) reg_wr(3'(4 + i), p[8*i +: 8]);
  endtask

  task automatic go(logic dir);
    reg_wr(3'd0, {4'b0, dir, 3'b000});
    reg_wr(3'd0, {4'b0, dir, 3'b001});
  endtask

  task automatic wait_idle(output logic [7:0] s);
    for (int i = 0; i < 80000; i++) begin
      reg_rd(3'd2, s);
      if (!s[0]) break;
    end
  endtask

  task automatic put_desc(int w, logic [31:0] a, logic [15:0] bytes, logic last);
    mem[w]     = a;
    mem[w + 1] = {last, 15'b0, bytes};
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 + 32'(i);
  endtask

  typedef struct packed {
    logic       dir;
    logic [7:0] n0;
    logic [7:0] n1;
    logic       slw;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 8'd4, 8'd0, 1'b0},
    '{1'b1, 8'd3, 8'd5, 1'b1},
    '{1'b0, 8'd6, 8'd0, 1'b0},
    '{1'b0, 8'd2, 8'd7, 1'b1},
    '{1'b1, 8'd1, 8'd1, 1'b0},
    '{1'b0, 8'd1, 8'd0, 1'b1}
  };

  initial begin
    #(8 * 195000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, b;
    logic [31:0] p;
    int bad, s0, n0, n1;
    vec_t c;

    tick(3);
    rst_ni = 1'b1;
    tick();

    // R1 reset values and unused offsets
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), s);
      chk("R1 reset value", s, 0);
    end
    set_ptr(32'h1234_5678);
    p = '0;
    for (int i = 0; i < 4; i++) begin
      reg_rd(3'(4 + i), b);
      p[8*i +: 8] = b;
    end
    chk("R1 pointer bytes low first", p, 32'h1234_5678);
    reg_wr(3'd0, 8'hFE);
    reg_rd(3'd0, s);
    chk("R1 command bits", s, 8'h08);
    reg_wr(3'd0, 8'h00);

    // R12 capability bits and ignored bits
    reg_wr(3'd2, 8'hFF);
    reg_rd(3'd2, s);
    chk("R12 status write all ones", s, 8'h60);
    reg_wr(3'd2, 8'h40);
    reg_rd(3'd2, s);
    chk("R12 capability rewrite", s, 8'h40);
    reg_wr(3'd2, 8'h60);

    // table-driven transfers: R3 R4 R5 R6 R14
    for (int v = 0; v < 6; v++) begin
      c = VECS[v];
      n0 = int'(c.n0);
      n1 = int'(c.n1);
      init_mem();
      put_desc(16, 32'h200, 16'(n0 * 4), (n1 == 0));
      if (n1 != 0) put_desc(18, 32'h400, 16'(n1 * 4), 1'b1);
      slow = c.slw;
      s0 = rd_seq; wr_n = 0; mem_wr_n = 0;
      set_ptr(32'h40);
      go(c.dir);
      wait_idle(s);
      chk("R6 idle at table end", 32'(s[2:0]), 0);
      bad = 0;
      if (c.dir) begin
        for (int i = 0; i < n0; i++)
          if (mem[128 + i] !== 32'hD000_0000 + 32'(s0 + i)) bad++;
        for (int j = 0; j < n1; j++)
          if (mem[256 + j] !== 32'hD000_0000 + 32'(s0 + n0 + j)) bad++;
        chk("R4/R3/R14 memory contents", bad, 0);
        chk("R4 memory write count", mem_wr_n, n0 + n1);
      end else begin
        for (int i = 0; i < n0; i++)
          if (dlog[i] !== 32'hA000_0000 + 32'(128 + i)) bad++;
        for (int j = 0; j < n1; j++)
          if (dlog[n0 + j] !== 32'hA000_0000 + 32'(256 + j)) bad++;
        chk("R5/R3/R14 device words", bad, 0);
        chk("R5 device word count", wr_n, n0 + n1);
      end
    end
    slow = 0;
    chk("R12 caps kept across transfers", 32'(s[6:5]), 2'b11);

    // R13 success encoding, R2 no restart without edge
    init_mem();
    put_desc(16, 32'h200, 16'd8, 1'b1);
    mem_wr_n = 0;
    go(1'b1);
    wait_idle(s);
    dev_irq_i = 1'b1; tick(); dev_irq_i = 1'b0;
    reg_rd(3'd2, s);
    chk("R13 success low bits", 32'(s[2:0]), 3'b100);
    reg_wr(3'd0, 8'h09);
    tick(3);
    reg_rd(3'd2, s);
    chk("R2 rewrite of set run bit", 32'(s[0]), 0);
    chk("R2 no extra writes", mem_wr_n, 2);
    reg_wr(3'd2, 8'h64);
    reg_rd(3'd2, s);
    chk("R11 interrupt cleared", 32'(s[2:0]), 0);

    // R7 stall, R10 busy with interrupt, R8 stop
    dev_en = 0; mem_wr_n = 0;
    put_desc(16, 32'h200, 16'd16, 1'b1);
    go(1'b1);
    tick(200);
    reg_rd(3'd2, s);
    chk("R7 active during stall", 32'(s[0]), 1);
    dev_irq_i = 1'b1; tick(); dev_irq_i = 1'b0;
    reg_rd(3'd2, s);
    chk("R10 active and interrupt", 32'(s[2:0]), 3'b101);
    reg_wr(3'd0, 8'h08);
    tick(2);
    dev_en = 1;
    tick(20);
    reg_rd(3'd2, s);
    chk("R8 idle after stop", 32'(s[0]), 0);
    chk("R8 no writes after stop", mem_wr_n, 0);

    // R11 set beats clear
    dev_irq_i = 1'b1;
    reg_wr(3'd2, 8'h64);
    reg_rd(3'd2, s);
    chk("R11 set wins over clear", 32'(s[2]), 1);
    dev_irq_i = 1'b0;
    reg_wr(3'd2, 8'h60);
    reg_rd(3'd2, s);
    chk("R11 write zero keeps bit", 32'(s[2]), 1);
    reg_wr(3'd2, 8'h64);
    reg_rd(3'd2, s);
    chk("R11 clear when quiet", 32'(s[2]), 0);

    // R9 memory error
    init_mem();
    put_desc(16, 32'h200, 16'd16, 1'b1);
    err_en = 1; err_addr = 32'h208; mem_wr_n = 0;
    go(1'b1);
    wait_idle(s);
    chk("R9 error status", 32'(s[2:0]), 3'b010);
    chk("R9 writes before error", mem_wr_n, 2);
    err_en = 0;
    reg_wr(3'd2, 8'h62);
    reg_rd(3'd2, s);
    chk("R11 error cleared", 32'(s[2:0]), 0);

    // R2 pointer taken only at start
    init_mem();
    put_desc(16, 32'h200, 16'd12, 1'b1);
    set_ptr(32'h40);
    wr_rdy = 0; wr_n = 0;
    go(1'b0);
    tick(10);
    set_ptr(32'h80);
    wr_rdy = 1;
    wait_idle(s);
    chk("R2 word count from old table", wr_n, 3);
    chk("R2 last word from old table", dlog[2], 32'hA000_0082);

    // R3 zero count is 64 KiB
    init_mem();
    put_desc(16, 32'h000, 16'h0000, 1'b1);
    set_ptr(32'h40);
    wr_n = 0;
    go(1'b0);
    wait_idle(s);
    chk("R3 zero count moves 16384 words", wr_n, 16384);
    chk("R6 idle after 64 KiB", 32'(s[0]), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule